// File: doc/BRIEF.md
# Operand Address Generator

This block turns the operand description of one instruction step of a small 8-bit controller core into a concrete memory reference. It takes an addressing-mode code, the 8-bit address or register field of the instruction and the live core state: the two-bit register-bank select, the R0 and R1 contents, the stack pointer, the 16-bit data pointer, the accumulator, the program counter and a page byte taken from an I/O port. From these it reports which address space is targeted, the resolved address and, for bit operands, the bit index inside the addressed byte.

Several spaces overlap on the same 8-bit numbers, so the mode decides whether a value points into internal RAM, the special function register (SFR) area, external data memory or program memory. Register numbers are folded into one of four banks, bit numbers are folded onto bit-capable bytes, and external accesses through R0/R1 take their upper byte from the port page. The result is registered and appears one clock after a request strobe together with a valid flag. A stack-pointer indirect request that is not tagged as a push or pop is flagged as an error.

Top module: `opaddr_gen`

## Requirements
- R1: Mode 0 (register): space internal RAM (space code 0), address = bank × 8 + field[2:0], so it always lies below 32.
- R2: Mode 1 (direct byte): a field of 0–127 gives space internal RAM (code 0), a field of 128–255 gives space SFR (code 1); the address equals the field in both cases.
- R3: Mode 2 (bit) with field 128–255: space SFR (code 1), address = field with its low three bits cleared, bit index = field[2:0], bit flag set; for example field 144 gives byte 90h, bit 0.
- R4: Mode 2 (bit) with field 0–127: space internal RAM (code 0), address = 20h + (field >> 3), bit index = field[2:0], bit flag set; the address is always in 20h–2Fh.
- R5: Mode 3 (indirect via R0/R1): field[0] = 1 selects R1, otherwise R0; space internal RAM (code 0) and address = that register's value.
- R6: Mode 4 (indirect via stack pointer): with the stack-operation input high, space internal RAM (code 0) and address = stack pointer, error flag low; with it low, the error flag is set, space code 0 and address 0.
- R7: Mode 5 (external through R0/R1, selected by field[0] as in R5): space external data (code 2), address = {port page, register value}.
- R8: Mode 6 (external through data pointer): space external data (code 2), address = data pointer.
- R9: Mode 7 (program memory): space code 3; field[0] = 1 gives program counter + accumulator, otherwise data pointer + accumulator, summed modulo 65536.
- R10: Results appear one clock after a cycle with the request strobe high, together with the valid flag; after a cycle without the strobe the valid flag is low and all other outputs keep their previous values. Bit flag and bit index are zero in every mode but 2, the error flag is zero except in R6's error case.
- R11: While reset is active all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing-mode code 0–7 |
| req_field | input | 8 | Address, bit number or register field |
| req_stack_op | input | 1 | Marks a stack-pointer indirect request as push or pop |
| bank_sel | input | 2 | Active register bank |
| r0_val | input | 8 | R0 of the active bank |
| r1_val | input | 8 | R1 of the active bank |
| sp_val | input | 8 | Stack pointer |
| dptr_val | input | 16 | Data pointer |
| acc_val | input | 8 | Accumulator |
| pc_val | input | 16 | Program counter |
| xpage_val | input | 8 | Port byte used as external page |
| out_valid | output | 1 | Result valid |
| out_space | output | 2 | 0 internal RAM, 1 SFR, 2 external data, 3 program memory |
| out_addr | output | 16 | Resolved address |
| out_bit_idx | output | 3 | Bit index for bit operands |
| out_is_bit | output | 1 | Operand is a single bit |
| out_err | output | 1 | Stack-pointer indirect without push/pop tag |

## Verification
Every stage is a single register, so a wrong decode shows at the ports in the very cycle after the request: a bad bank fold or bit fold moves the address by a multiple of eight, a wrong range split flips the space code between RAM and SFR, and a dropped carry in the program-memory sum changes the upper address byte. A wrong hold or valid path shows on the first idle cycle, when the outputs change or the valid flag stays high. The comparison against the bench's model each clock therefore localizes a fault to the request that caused it.

// File: rtl/oag_pkg.sv
package oag_pkg;

  localparam int BYTE_W   = 8;
  localparam int WIDE_W   = 16;
  localparam int BANK_W   = 2;
  localparam int REGN_W   = 3;
  localparam int BIDX_W   = 3;
  localparam int MODE_W   = 3;
  localparam logic [BYTE_W-1:0] RAM_BIT_BASE = 8'h20;

  typedef enum logic [MODE_W-1:0] {
    AM_REG    = 3'd0,
    AM_DIR    = 3'd1,
    AM_BIT    = 3'd2,
    AM_IND_RI = 3'd3,
    AM_IND_SP = 3'd4,
    AM_XR_RI  = 3'd5,
    AM_XR_DP  = 3'd6,
    AM_CODE   = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SPC_IRAM = 2'd0,
    SPC_SFR  = 2'd1,
    SPC_XRAM = 2'd2,
    SPC_CODE = 2'd3
  } space_e;

  typedef struct packed {
    space_e              space;
    logic [WIDE_W-1:0]   addr;
    logic [BIDX_W-1:0]   bidx;
    logic                is_bit;
    logic                err;
  } res_t;

  // bank fold: bank number times register count plus register number
  function automatic logic [WIDE_W-1:0] bank_addr(
    input logic [BANK_W-1:0] bank, input logic [REGN_W-1:0] rnum);
    logic [WIDE_W-1:0] r;
    r = '0;
    r[BANK_W+REGN_W-1:0] = {bank, rnum};
    return r;
  endfunction

  // byte holding a bit in the SFR area: low bits cleared
  function automatic logic [WIDE_W-1:0] sfr_bit_byte(input logic [BYTE_W-1:0] b);
    logic [WIDE_W-1:0] r;
    r = '0;
    r[BYTE_W-1:BIDX_W] = b[BYTE_W-1:BIDX_W];
    return r;
  endfunction

  // byte holding a bit in the RAM bit window
  function automatic logic [WIDE_W-1:0] ram_bit_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] s;
    s = RAM_BIT_BASE + (b >> BIDX_W);
    return {{(WIDE_W-BYTE_W){1'b0}}, s};
  endfunction

  // base plus index, wraps modulo 2^WIDE_W
  function automatic logic [WIDE_W-1:0] code_sum(
    input logic [WIDE_W-1:0] base, input logic [BYTE_W-1:0] idx);
    return base + {{(WIDE_W-BYTE_W){1'b0}}, idx};
  endfunction

endpackage

// File: rtl/oag_internal.sv
module oag_internal
  import oag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  amode_e            mode,
  input  logic [BYTE_W-1:0] field,
  input  logic              stack_op,
  input  logic [BANK_W-1:0] bank,
  input  logic [BYTE_W-1:0] r0,
  input  logic [BYTE_W-1:0] r1,
  input  logic [BYTE_W-1:0] sp,
  output res_t              res,
  output logic              hit,
  output logic              sp_misuse
);

  logic [BYTE_W-1:0] ri;
  logic              upper_half;

  assign ri         = field[0] ? r1 : r0;
  assign upper_half = field[BYTE_W-1];
  assign sp_misuse  = (mode == AM_IND_SP) && !stack_op;

  always_comb begin
    res = '0;
    hit = 1'b1;
    case (mode)
      AM_REG: begin
        res.space = SPC_IRAM;
        res.addr  = bank_addr(bank, field[REGN_W-1:0]);
      end
      AM_DIR: begin
        res.space = upper_half ? SPC_SFR : SPC_IRAM;
        res.addr  = {{(WIDE_W-BYTE_W){1'b0}}, field};
      end
      AM_BIT: begin
        res.is_bit = 1'b1;
        res.bidx   = field[BIDX_W-1:0];
        if (upper_half) begin
          res.space = SPC_SFR;
          res.addr  = sfr_bit_byte(field);
        end else begin
          res.space = SPC_IRAM;
          res.addr  = ram_bit_byte(field);
        end
      end
      AM_IND_RI: begin
        res.space = SPC_IRAM;
        res.addr  = {{(WIDE_W-BYTE_W){1'b0}}, ri};
      end
      AM_IND_SP: begin
        res.space = SPC_IRAM;
        if (sp_misuse) res.err = 1'b1;
        else           res.addr = {{(WIDE_W-BYTE_W){1'b0}}, sp};
      end
      default: hit = 1'b0;
    endcase
  end

  // R1
  reg_in_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_REG) |-> (res.addr < 16'd32));

  // R4
  ram_bit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_BIT && !field[BYTE_W-1]) |->
      (res.addr >= 16'h0020 && res.addr <= 16'h002F && res.space == SPC_IRAM));

  // R6
  err_only_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res.err |-> (mode == AM_IND_SP && !stack_op && res.addr == '0));

endmodule

// File: rtl/oag_external.sv
module oag_external
  import oag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  amode_e            mode,
  input  logic              ptr_sel,
  input  logic [BYTE_W-1:0] r0,
  input  logic [BYTE_W-1:0] r1,
  input  logic [BYTE_W-1:0] xpage,
  input  logic [WIDE_W-1:0] dptr,
  input  logic [BYTE_W-1:0] acc,
  input  logic [WIDE_W-1:0] pc,
  output res_t              res,
  output logic              hit
);

  logic [BYTE_W-1:0] ri;
  logic [WIDE_W-1:0] code_base;

  assign ri        = ptr_sel ? r1 : r0;
  assign code_base = ptr_sel ? pc : dptr;

  always_comb begin
    res = '0;
    hit = 1'b1;
    case (mode)
      AM_XR_RI: begin
        res.space = SPC_XRAM;
        res.addr  = {xpage, ri};
      end
      AM_XR_DP: begin
        res.space = SPC_XRAM;
        res.addr  = dptr;
      end
      AM_CODE: begin
        res.space = SPC_CODE;
        res.addr  = code_sum(code_base, acc);
      end
      default: hit = 1'b0;
    endcase
  end

  // R7
  page_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_XR_RI) |-> (res.addr[WIDE_W-1:BYTE_W] == xpage));

  // R9
  code_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_CODE) |-> (res.space == SPC_CODE && !res.is_bit && !res.err));

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import oag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_mode,
  input  logic [7:0]  req_field,
  input  logic        req_stack_op,
  input  logic [1:0]  bank_sel,
  input  logic [7:0]  r0_val,
  input  logic [7:0]  r1_val,
  input  logic [7:0]  sp_val,
  input  logic [15:0] dptr_val,
  input  logic [7:0]  acc_val,
  input  logic [15:0] pc_val,
  input  logic [7:0]  xpage_val,
  output logic        out_valid,
  output logic [1:0]  out_space,
  output logic [15:0] out_addr,
  output logic [2:0]  out_bit_idx,
  output logic        out_is_bit,
  output logic        out_err
);

  amode_e mode;
  res_t   int_res, ext_res, sel_res, res_q;
  logic   int_hit, ext_hit, sp_misuse;
  logic   valid_q;

  assign mode = amode_e'(req_mode);

  oag_internal u_int (
    .clk(clk), .rst_n(rst_n), .mode(mode), .field(req_field),
    .stack_op(req_stack_op), .bank(bank_sel), .r0(r0_val), .r1(r1_val),
    .sp(sp_val), .res(int_res), .hit(int_hit), .sp_misuse(sp_misuse)
  );

  oag_external u_ext (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ptr_sel(req_field[0]),
    .r0(r0_val), .r1(r1_val), .xpage(xpage_val), .dptr(dptr_val),
    .acc(acc_val), .pc(pc_val), .res(ext_res), .hit(ext_hit)
  );

  assign sel_res = int_hit ? int_res : ext_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) res_q <= sel_res;
    end
  end

  assign out_valid   = valid_q;
  assign out_space   = res_q.space;
  assign out_addr    = res_q.addr;
  assign out_bit_idx = res_q.bidx;
  assign out_is_bit  = res_q.is_bit;
  assign out_err     = res_q.err;

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_space)));

  // R6
  sp_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sp_misuse) |=> (out_err && out_addr == '0));

  // R3
  sfr_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_bit && out_space == SPC_SFR) |-> (out_addr[2:0] == 3'd0));

  // R10
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({int_hit, ext_hit}) == 1);

endmodule

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [7:0]  req_field = '0;
  logic        req_stack_op = 1'b0;
  logic [1:0]  bank_sel = '0;
  logic [7:0]  r0_val = '0, r1_val = '0, sp_val = '0, acc_val = '0, xpage_val = '0;
  logic [15:0] dptr_val = '0, pc_val = '0;
  logic        out_valid, out_is_bit, out_err;
  logic [1:0]  out_space;
  logic [15:0] out_addr;
  logic [2:0]  out_bit_idx;

  int total = 0;
  int bad = 0;
  bit running = 0;

  // model state
  int e_valid = 0, e_space = 0, e_addr = 0, e_idx = 0, e_bit = 0, e_err = 0;
  string e_tag = "R11";

  opaddr_gen uut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic string tag_of(int m, int f);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return (f >= 128) ? "R3" : "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // behavioural reference, integer arithmetic
  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_space = 0; e_addr = 0; e_idx = 0; e_bit = 0; e_err = 0;
      e_tag = "R11";
    end else if (!req_valid) begin
      e_valid = 0;
      e_tag = "R10";
    end else begin
      int m, f, ri;
      m = int'(req_mode); f = int'(req_field);
      ri = (f % 2 == 1) ? int'(r1_val) : int'(r0_val);
      e_valid = 1; e_idx = 0; e_bit = 0; e_err = 0;
      e_tag = tag_of(m, f);
      case (m)
        0: begin e_space = 0; e_addr = int'(bank_sel) * 8 + (f % 8); end
        1: begin e_space = (f < 128) ? 0 : 1; e_addr = f; end
        2: begin
          e_bit = 1; e_idx = f % 8;
          if (f >= 128) begin e_space = 1; e_addr = f - (f % 8); end
          else begin e_space = 0; e_addr = 32 + f / 8; end
        end
        3: begin e_space = 0; e_addr = ri; end
        4: begin
          e_space = 0;
          if (req_stack_op) e_addr = int'(sp_val);
          else begin e_addr = 0; e_err = 1; end
        end
        5: begin e_space = 2; e_addr = int'(xpage_val) * 256 + ri; end
        6: begin e_space = 2; e_addr = int'(dptr_val); end
        default: begin
          e_space = 3;
          e_addr = ((f % 2 == 1 ? int'(pc_val) : int'(dptr_val)) + int'(acc_val)) % 65536;
        end
      endcase
    end
  end

  task automatic check_now(string tag);
    bit ok;
    total++;
    ok = (int'(out_valid) == e_valid) && (int'(out_space) == e_space) &&
         (int'(out_addr) == e_addr) && (int'(out_bit_idx) == e_idx) &&
         (int'(out_is_bit) == e_bit) && (int'(out_err) == e_err);
    if (!ok) begin
      bad++;
      $display("FAIL %s: got v=%0d sp=%0d a=%h i=%0d b=%0d e=%0d exp v=%0d sp=%0d a=%h i=%0d b=%0d e=%0d",
               tag, out_valid, out_space, out_addr, out_bit_idx, out_is_bit, out_err,
               e_valid, e_space, e_addr[15:0], e_idx, e_bit, e_err);
    end
  endtask

  always @(negedge clk) if (running) check_now(e_tag);

  task automatic req(int m, int f, bit st);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'(m); req_field = 8'(f); req_stack_op = st;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_mode = 3'($urandom); req_field = 8'($urandom); req_stack_op = 1'($urandom);
      xpage_val = 8'($urandom); sp_val = 8'($urandom);
    end
  endtask

  initial begin
    #(CLK_P*100000);
    total++; bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req_mode = 3'd7; req_field = 8'hFF; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state, even with a strobe applied
    check_now("R11");
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    bank_sel = 2'd2; r0_val = 8'h45; r1_val = 8'hC3; sp_val = 8'h07;
    dptr_val = 16'h1234; acc_val = 8'hF0; pc_val = 16'hFF20; xpage_val = 8'h9A;
    req(0, 5, 0);          // R1 bank 2 reg 5 -> 21
    req(0, 8'hFF, 0);      // R1 only low bits count -> 23
    req(1, 127, 0);        // R2 top of RAM
    req(1, 128, 0);        // R2 first SFR
    req(2, 144, 0);        // R3 byte 90h bit 0
    req(2, 8'h97, 0);      // R3 byte 90h bit 7
    req(2, 8'h7F, 0);      // R4 byte 2Fh bit 7
    req(2, 0, 0);          // R4 byte 20h bit 0
    req(3, 0, 0);          // R5 R0
    req(3, 1, 0);          // R5 R1
    req(4, 0, 1);          // R6 push/pop
    req(4, 0, 0);          // R6 misuse
    req(5, 1, 0);          // R7 page:R1
    req(6, 0, 0);          // R8
    req(7, 0, 0);          // R9 dptr+acc
    req(7, 1, 0);          // R9 pc+acc wraps to 0010h
    idle(3);               // R10 hold with noise
    req(4, 0, 0);          // R6 error cleared by next
    req(2, 9, 0);          // R10 bit flag only in bit mode, err cleared
    req(6, 0, 0);
    idle(1);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      req_valid = ($urandom % 4) != 0;
      req_mode = 3'($urandom); req_field = 8'($urandom); req_stack_op = 1'($urandom);
      bank_sel = 2'($urandom); r0_val = 8'($urandom); r1_val = 8'($urandom);
      sp_val = 8'($urandom); dptr_val = 16'($urandom); acc_val = 8'($urandom);
      pc_val = 16'($urandom); xpage_val = 8'($urandom);
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    running = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule